// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that watches a free-running timer count supplied from outside. In capture mode it watches an event input and, on the edge type chosen in its control register, records the timer count into a two-entry holding buffer. Software reads the oldest held value through the time register and pops it with a read strobe. A second event can therefore be taken before the first one is read. A third event that arrives while both entries are full is flagged as an overrun.

In compare mode the time register holds a match value. A write replaces that value at once, with no buffering. On every cycle where the timer count equals the match value, the channel sets, clears or toggles its output pin as the control register selects. Both modes raise a one-cycle interrupt request for each event they handle.

Top module: `tcc_channel`

## Requirements
- R1: After reset, `time_rd`, `ctrl_rd`, `pin_out`, `irq` and `overrun` are all zero. Control value zero means capture mode with no edge enabled.
- R2: The control register is 5 bits: bit 0 is the mode (0 capture, 1 compare), bits 2:1 are the edge select, and bits 4:3 are the compare action. `ctrl_rd` returns the written value. A control write empties the capture buffer and clears `overrun`.
- R3: The edge select codes are 00 none, 01 rising, 10 falling and 11 both. A capture stores the `timer_val` present at the clock edge where `evt_in` is first seen at its new level. With code 00, nothing is captured.
- R4: In capture mode, `time_rd` shows the oldest held capture, or zero when the buffer is empty. A `rd_pop` strobe discards the oldest capture and brings the next one forward.
- R5: A capture that arrives while both entries are full replaces the newer entry, keeps the oldest, and sets `overrun`. `overrun` stays set until the next control write.
- R6: A capture and a pop in the same cycle on a full buffer do not set `overrun`. The buffer ends up holding the second entry followed by the new value.
- R7: In compare mode, a time write (`wr_sel`=1) replaces the match value for the next cycle. `time_rd` shows the match value, and `rd_pop` has no effect on it.
- R8: In compare mode, a cycle where `timer_val` equals the match value applies the action to `pin_out` at that clock edge. Action 00 leaves the pin unchanged, 01 sets it, 10 clears it and 11 toggles it.
- R9: `irq` is high for the one cycle after each accepted capture and after each compare match.
- R10: In capture mode, time writes are ignored, and a timer value equal to the match value changes neither `pin_out` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | TW | Free-running timer count |
| evt_in | input | 1 | Capture event input (synchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects time register |
| wr_data | input | TW | Write data |
| rd_pop | input | 1 | Consume the oldest capture |
| ctrl_rd | output | 5 | Control register contents |
| time_rd | output | TW | Time register view |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | One-cycle interrupt request |
| overrun | output | 1 | Sticky capture overrun flag |

## Verification
A wrong buffer count or a misplaced entry appears on `time_rd` at the next pop. It can also appear as `overrun` rising one capture early or late, so every scenario drains the buffer and checks each value it pops. An edge detector that holds the wrong previous level shows up on `irq` in the cycle right after the event edge. A wrong compare path shows up on `pin_out` and `irq` in the cycle right after the matching count. This is checked both one count before and one count after the match.

// File: rtl/tcc_pkg.sv
// Shared types for the timer capture/compare channel.
// Assumes: control layout is {action[1:0], edge[1:0], mode}, mode in bit 0.
package tcc_pkg;
    localparam int CTRL_W = 5;

    typedef enum logic {
        MODE_CAP = 1'b0,
        MODE_CMP = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef struct packed {
        act_e  act;
        edge_e edge_sel;
        mode_e mode;
    } ctrl_t;
endpackage

// File: rtl/tcc_edge_det.sv
// Edge detector for the capture input.
// Optional synchronizer stages (SYNC_STAGES = 0 means the input is already
// synchronous). Flags a hit in the cycle the selected transition is seen.
module tcc_edge_det
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  evt_in,
    input  edge_e edge_sel,
    output logic  evt_hit
);
    logic evt_s;
    logic prev_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign evt_s = evt_in;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], evt_in};
            end
            assign evt_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Remember the last seen level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= evt_s;
    end

    // Decode the selected transition.
    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: evt_hit = evt_s & ~prev_q;
            EDGE_FALL: evt_hit = ~evt_s & prev_q;
            EDGE_BOTH: evt_hit = evt_s ^ prev_q;
            default:   evt_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_cap_buf.sv
// Two-entry capture holding buffer with a sticky overrun flag.
// Assumes push/pop are already qualified by capture mode. Flush wins over
// push and pop. A push into a full buffer replaces the newer entry.
module tcc_cap_buf #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [TW-1:0] din,
    output logic [TW-1:0] head,
    output logic          overrun
);
    logic [TW-1:0] ent0_q, ent1_q;
    logic [1:0]    cnt_q;

    // Update entries and occupancy for push/pop/flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ent0_q <= '0;
            ent1_q <= '0;
            cnt_q  <= 2'd0;
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    if (cnt_q == 2'd0) begin
                        ent0_q <= din;
                        cnt_q  <= 2'd1;
                    end else begin
                        ent1_q <= din;
                        cnt_q  <= 2'd2;
                    end
                end
                2'b01: begin
                    if (cnt_q == 2'd2) begin
                        ent0_q <= ent1_q;
                        cnt_q  <= 2'd1;
                    end else begin
                        cnt_q  <= 2'd0;
                    end
                end
                2'b11: begin
                    if (cnt_q == 2'd2) begin
                        ent0_q <= ent1_q;
                        ent1_q <= din;
                    end else begin
                        ent0_q <= din;
                        cnt_q  <= 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sticky overrun: set by a push into a full buffer with no pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                          overrun <= 1'b0;
        else if (push && !pop && cnt_q == 2'd2)       overrun <= 1'b1;
    end

    assign head = (cnt_q == 2'd0) ? '0 : ent0_q;
endmodule

// File: rtl/tcc_cmp_unit.sv
// Compare unit: holds the match value and drives the output pin.
// Assumes enable is high only in compare mode. A write takes effect for the
// next cycle; the current cycle compares against the old value.
module tcc_cmp_unit
    import tcc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  act_e          act,
    input  logic          wr_match,
    input  logic [TW-1:0] wr_val,
    input  logic [TW-1:0] timer_val,
    output logic [TW-1:0] match_val,
    output logic          hit,
    output logic          pin_out
);
    // Replace the match value on a write (no buffering).
    always_ff @(posedge clk) begin
        if (!rst_n)        match_val <= '0;
        else if (wr_match) match_val <= wr_val;
    end

    assign hit = enable && (timer_val == match_val);

    // Apply the selected pin action on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= 1'b0;
        else if (hit) begin
            unique case (act)
                ACT_SET: pin_out <= 1'b1;
                ACT_CLR: pin_out <= 1'b0;
                ACT_TGL: pin_out <= ~pin_out;
                default: pin_out <= pin_out;
            endcase
        end
    end
endmodule

// File: rtl/tcc_channel.sv
// Top of the timer capture/compare channel: control register, read mux,
// interrupt register. Assumes timer_val and evt_in are in the clk domain.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_val,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [TW-1:0]     wr_data,
    input  logic              rd_pop,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [TW-1:0]     time_rd,
    output logic              pin_out,
    output logic              irq,
    output logic              overrun
);
    ctrl_t         ctrl_q;
    logic          ctrl_wr, time_wr, is_cmp;
    logic          evt_hit, cap_push, cmp_hit;
    logic [TW-1:0] cap_head, match_val;

    assign ctrl_wr  = wr_en && !wr_sel;
    assign is_cmp   = (ctrl_q.mode == MODE_CMP);
    assign time_wr  = wr_en && wr_sel && is_cmp;
    assign cap_push = !is_cmp && evt_hit && !ctrl_wr;

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    tcc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .edge_sel (ctrl_q.edge_sel),
        .evt_hit  (evt_hit)
    );

    tcc_cap_buf #(.TW(TW)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (ctrl_wr),
        .push    (cap_push),
        .pop     (rd_pop && !is_cmp),
        .din     (timer_val),
        .head    (cap_head),
        .overrun (overrun)
    );

    tcc_cmp_unit #(.TW(TW)) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (is_cmp),
        .act       (ctrl_q.act),
        .wr_match  (time_wr),
        .wr_val    (wr_data),
        .timer_val (timer_val),
        .match_val (match_val),
        .hit       (cmp_hit),
        .pin_out   (pin_out)
    );

    // One-cycle interrupt for each accepted capture or compare match.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= cap_push | cmp_hit;
    end

    assign ctrl_rd = ctrl_q;
    assign time_rd = is_cmp ? match_val : cap_head;
endmodule

// File: rtl/tcc_channel_chk.sv
// Port-level properties of the capture/compare channel, bound to the top.
module tcc_channel_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] timer_val,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [4:0]    ctrl_rd,
    input logic [TW-1:0] time_rd,
    input logic          pin_out,
    input logic          irq,
    input logic          overrun
);
    AST_CTRL_WR_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> !overrun); // R2
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(wr_en && !wr_sel)) |=> overrun); // R5
    AST_CMP_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && !wr_en) |=> $stable(time_rd)); // R7
    AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && timer_val == time_rd) |=> irq); // R9
    AST_CAP_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[0]) |=> $stable(pin_out)); // R10
endmodule

bind tcc_channel tcc_channel_chk #(.TW(TW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .ctrl_rd   (ctrl_rd),
    .time_rd   (time_rd),
    .pin_out   (pin_out),
    .irq       (irq),
    .overrun   (overrun)
);

// File: tb/tcc_channel_tb_top.sv
// Directed bench for the capture/compare channel.
module tcc_channel_tb_top;
    localparam int TW = 16;
    localparam logic [TW-1:0] IDLE_T = 16'hFFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] timer_val = IDLE_T;
    logic          evt_in = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [TW-1:0] wr_data = '0;
    logic          rd_pop = 1'b0;
    logic [4:0]    ctrl_rd;
    logic [TW-1:0] time_rd;
    logic          pin_out, irq, overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tcc_channel #(.TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .evt_in(evt_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_pop(rd_pop),
        .ctrl_rd(ctrl_rd), .time_rd(time_rd), .pin_out(pin_out),
        .irq(irq), .overrun(overrun)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(logic [4:0] v);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = TW'(v);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic wr_time(logic [TW-1:0] v);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic evt_step(logic lvl, logic [TW-1:0] t);
        evt_in = lvl; timer_val = t;
        tick();
        timer_val = IDLE_T;
    endtask

    task automatic t_reset();
        check("R1 time_rd", time_rd, 0);
        check("R1 ctrl_rd", ctrl_rd, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 irq", irq, 0);
        check("R1 overrun", overrun, 0);
    endtask

    task automatic t_rise_overrun();
        wr_ctrl(5'b00010);
        check("R2 ctrl readback", ctrl_rd, 5'b00010);
        evt_step(1, 100);
        check("R9 capture irq", irq, 1);
        check("R4 head", time_rd, 100);
        evt_step(0, 150);
        check("R3 falling ignored", irq, 0);
        evt_step(1, 200);
        evt_step(0, 250);
        check("R4 oldest kept", time_rd, 100);
        check("R5 no overrun yet", overrun, 0);
        evt_step(1, 300);
        check("R5 overrun set", overrun, 1);
        check("R5 oldest preserved", time_rd, 100);
        pop();
        check("R5 newer replaced", time_rd, 300);
        pop();
        check("R4 empty reads zero", time_rd, 0);
        check("R5 sticky", overrun, 1);
        evt_in = 1'b0;
        tick();
        wr_ctrl(5'b00010);
        check("R2 ctrl write clears overrun", overrun, 0);
    endtask

    task automatic t_falling_both_none();
        wr_ctrl(5'b00100);
        evt_step(1, 40);
        check("R3 rising ignored in falling", irq, 0);
        evt_step(0, 55);
        check("R3 falling capture irq", irq, 1);
        check("R3 falling value", time_rd, 55);
        wr_ctrl(5'b00110);
        check("R2 flush on ctrl write", time_rd, 0);
        evt_step(1, 10);
        evt_step(0, 20);
        check("R3 both first", time_rd, 10);
        pop();
        check("R3 both second", time_rd, 20);
        pop();
        wr_ctrl(5'b00000);
        evt_step(1, 77);
        check("R3 none no irq", irq, 0);
        evt_step(0, 78);
        check("R3 none no capture", time_rd, 0);
    endtask

    task automatic t_pop_push_full();
        wr_ctrl(5'b00010);
        evt_step(1, 1);
        evt_step(0, 0);
        evt_step(1, 2);
        evt_step(0, 0);
        rd_pop = 1'b1;
        evt_step(1, 3);
        rd_pop = 1'b0;
        check("R6 no overrun", overrun, 0);
        check("R6 head advanced", time_rd, 2);
        pop();
        check("R6 new value behind", time_rd, 3);
        pop();
        evt_in = 1'b0;
        tick();
    endtask

    task automatic t_compare();
        wr_ctrl(5'b01001);
        check("R8 ctrl write leaves pin", pin_out, 0);
        wr_time(500);
        check("R7 match readback", time_rd, 500);
        pop();
        check("R7 pop no effect", time_rd, 500);
        timer_val = 499; tick();
        check("R8 no early match", pin_out, 0);
        check("R9 no early irq", irq, 0);
        timer_val = 500; tick();
        check("R8 set action", pin_out, 1);
        check("R9 match irq", irq, 1);
        timer_val = 501; tick();
        check("R9 irq one cycle", irq, 0);
        timer_val = IDLE_T;
        wr_ctrl(5'b10001);
        wr_time(600);
        timer_val = 600; tick(); timer_val = IDLE_T;
        check("R8 clear action", pin_out, 0);
        wr_ctrl(5'b11001);
        wr_time(700);
        timer_val = 700; tick();
        check("R8 toggle up", pin_out, 1);
        timer_val = 701; tick();
        timer_val = 700; tick(); timer_val = IDLE_T;
        check("R8 toggle down", pin_out, 0);
        wr_ctrl(5'b00001);
        wr_time(800);
        timer_val = 800; tick(); timer_val = IDLE_T;
        check("R8 no action keeps pin", pin_out, 0);
        check("R9 no-action match irq", irq, 1);
        wr_ctrl(5'b01001);
        wr_time(810);
        wr_time(900);
        timer_val = 810; tick();
        check("R7 old value replaced", irq, 0);
        timer_val = 900; tick(); timer_val = IDLE_T;
        check("R7 new value matches", irq, 1);
    endtask

    task automatic t_capture_ignores();
        wr_ctrl(5'b01010);
        wr_time(1234);
        check("R10 time write ignored", time_rd, 0);
        timer_val = 900; tick(); timer_val = IDLE_T;
        check("R10 pin unchanged", pin_out, 1);
        check("R10 no irq", irq, 0);
        wr_ctrl(5'b01001);
        check("R10 match value kept", time_rd, 900);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_rise_overrun();
        t_falling_both_none();
        t_pop_push_full();
        t_compare();
        t_capture_ignores();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule